// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a synchronous request port inside the chip and an external asynchronous static RAM of 8192 bytes. The memory has an active-low chip select, an active-high second select, an active-low write strobe, an active-low output strobe and one shared bidirectional data bus. On every rising clock edge the block can accept one request: a read or a write, with an address and, for a write, a data byte.

The request is stored at the rising edge, so the external address is steady for the whole of the following cycle. The strobes are derived from the clock phase and are never sequenced by a state machine. In the high half of the clock all strobes are inactive and the bus is released. In the low half the selected strobes go low. The rising edge that ends the low half commits a write, because the chip select rises at that edge, and the same edge captures read data into a register.

The bus is split into an output value, an output enable and an input value. The pad or board level joins these three signals into the shared wire. A captured read is reported with a one-cycle valid pulse.

Top module: `async_sram_ctrl`

## Requirements
- R1: While reset is held and after it is released with no request, mem_ce1_n, mem_we_n and mem_oe_n are 1, mem_dq_oe is 0 and rd_valid is 0.
- R2: A request presented with req_valid=1 is stored at a rising edge. During the cycle that follows, mem_addr equals that request's address.
- R3: While the clock is high, mem_ce1_n, mem_we_n and mem_oe_n are all 1 and mem_dq_oe is 0, whatever is pending.
- R4: For a stored write (req_write=1), in the clock-low half: mem_ce1_n=0, mem_we_n=0, mem_oe_n=1, mem_dq_oe=1 and mem_dq_o equals the write byte. The byte is held in the memory from the rising edge that ends that half.
- R5: For a stored read (req_write=0), in the clock-low half: mem_ce1_n=0, mem_oe_n=0, mem_we_n=1 and mem_dq_oe=0.
- R6: mem_dq_i is captured at the rising edge that ends a read's low half. After that edge, rd_data holds the byte and rd_valid is 1 for exactly one cycle. rd_data keeps its value until the next read.
- R7: In a cycle that follows an edge with req_valid=0, no strobe goes low in the low half.
- R8: mem_ce2 is 1 at all times.
- R9: The controller and the memory never drive the bus in the same cycle.
- R10: Requests on consecutive cycles, in any mix of reads and writes, are each carried out in their own cycle without loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; its low half is the memory access window |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Request address |
| req_wdata | input | 8 | Write byte |
| rd_data | output | 8 | Last captured read byte |
| rd_valid | output | 1 | One-cycle pulse when rd_data is fresh |
| mem_addr | output | 13 | Address to the memory |
| mem_ce1_n | output | 1 | Active-low chip select |
| mem_ce2 | output | 1 | Second chip select, held high |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output strobe |
| mem_dq_o | output | 8 | Byte the controller drives onto the bus |
| mem_dq_oe | output | 1 | Controller bus driver enable |
| mem_dq_i | input | 8 | Byte seen on the bus |

## Verification
The assertions check phase discipline on every cycle. Strobes and the bus driver must be inactive while the clock is high. The write and output strobes must never be low together. A write strobe needs the chip select and the bus driver. A read-valid pulse must follow a low half in which the output strobe was low. The assertions also check that a stored request's address reaches the memory pins.

Only the bench scenarios can show the data path: bytes landing in the memory at the closing edge, the values read back, the one-cycle pulse, back-to-back mixed traffic, and the behavioural memory's contention monitor.

// File: rtl/sram_if_pkg.sv
package sram_if_pkg;

    // Kind of access held for the current cycle.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } sram_op_e;

    // Active-low strobe set sent to the memory.
    typedef struct packed {
        logic ce1_n;
        logic we_n;
        logic oe_n;
        logic drive;
    } sram_strobe_t;

    localparam sram_strobe_t STROBE_IDLE = '{ce1_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};

endpackage

// File: rtl/sram_req_stage.sv
module sram_req_stage
    import sram_if_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output sram_op_e          op_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q
);

    typedef struct packed {
        sram_op_e          op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (req_valid) begin
            st_d.op   = req_write ? OP_WRITE : OP_READ;
            st_d.addr = req_addr;
            // A read keeps the old byte so the driver value does not toggle.
            if (req_write) begin
                st_d.wdata = req_wdata;
            end
        end else begin
            // Address and byte stay put while idle; only the operation clears.
            st_d.op = OP_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{op: OP_IDLE, addr: '0, wdata: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign op_q    = st_q.op;
    assign addr_q  = st_q.addr;
    assign wdata_q = st_q.wdata;

    // R2: a presented request is the one held for the following cycle.
    a_r2_request_held: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (op_q != OP_IDLE) && (addr_q == $past(req_addr)));

    // R7: no request means nothing is held.
    a_r7_idle_held: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (op_q == OP_IDLE));

endmodule

// File: rtl/sram_strobe_gen.sv
module sram_strobe_gen
    import sram_if_pkg::*;
(
    input  logic     clk,
    input  sram_op_e op_q,
    output logic     ce1_n,
    output logic     ce2,
    output logic     we_n,
    output logic     oe_n,
    output logic     dq_oe
);

    sram_strobe_t strobe;
    logic         low_phase;

    assign low_phase = ~clk;

    always_comb begin
        strobe = STROBE_IDLE;
        if (low_phase) begin
            unique case (op_q)
                OP_WRITE: begin
                    strobe.ce1_n = 1'b0;
                    strobe.we_n  = 1'b0;
                    strobe.drive = 1'b1;
                end
                OP_READ: begin
                    strobe.ce1_n = 1'b0;
                    strobe.oe_n  = 1'b0;
                end
                default: strobe = STROBE_IDLE;
            endcase
        end
    end

    assign ce1_n = strobe.ce1_n;
    assign we_n  = strobe.we_n;
    assign oe_n  = strobe.oe_n;
    assign dq_oe = strobe.drive;
    assign ce2   = 1'b1;

endmodule

// File: rtl/sram_read_capture.sv
module sram_read_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d       = cap_q;
        cap_d.valid = capture;
        if (capture) begin
            cap_d.data = bus_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '{data: '0, valid: 1'b0};
        end else begin
            cap_q <= cap_d;
        end
    end

    assign rd_data  = cap_q.data;
    assign rd_valid = cap_q.valid;

    // R6: captured byte stays put when no read closes.
    a_r6_data_hold: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(rd_data));

endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
    import sram_if_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce1_n,
    output logic              mem_ce2,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);

    sram_op_e          op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              read_closing;

    sram_req_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .op_q      (op_q),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q)
    );

    sram_strobe_gen u_strobe (
        .clk   (clk),
        .op_q  (op_q),
        .ce1_n (mem_ce1_n),
        .ce2   (mem_ce2),
        .we_n  (mem_we_n),
        .oe_n  (mem_oe_n),
        .dq_oe (mem_dq_oe)
    );

    // The read whose low half ends at this edge is the one held now.
    assign read_closing = (op_q == OP_READ);

    sram_read_capture #(.DATA_W(DATA_W)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .capture  (read_closing),
        .bus_in   (mem_dq_i),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    assign mem_addr = addr_q;
    assign mem_dq_o = wdata_q;

    // R3: sampled just before the falling edge, i.e. in the high half.
    a_r3_high_half_quiet: assert property (@(negedge clk) disable iff (rst)
        mem_ce1_n && mem_we_n && mem_oe_n && !mem_dq_oe);

    // R9: write and output strobes never low together (end of low half).
    a_r9_no_dual_strobe: assert property (@(posedge clk) disable iff (rst)
        !(!mem_we_n && !mem_oe_n));

    // R4: a write strobe comes with chip select and the bus driver.
    a_r4_write_drives: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_ce1_n && mem_dq_oe));

    // R6: a valid pulse follows a low half with the output strobe low.
    a_r6_valid_after_read: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(!mem_oe_n));

endmodule

// File: tb/async_sram_ctrl_test.sv
`timescale 1ns/100ps
module async_sram_ctrl_test;

    localparam int AW = 13;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [DW-1:0] rd_data;
    logic          rd_valid;
    logic [AW-1:0] mem_addr;
    logic          mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_o;
    logic [DW-1:0] mem_dq_i = '0;

    int checks = 0;
    int errors = 0;
    int contention = 0;

    always #2 clk = ~clk;

    async_sram_ctrl #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
        .rd_valid(rd_valid), .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n),
        .mem_ce2(mem_ce2), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    // Behavioural memory: samples the pins mid low half, holds its output
    // until the next low half, commits writes at the closing rising edge.
    logic [DW-1:0] mem [int];
    logic          s_wr = 1'b0;
    logic [AW-1:0] s_a = '0;
    logic [DW-1:0] s_d = '0;

    function automatic logic [DW-1:0] peek(input logic [AW-1:0] a);
        return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
    endfunction

    always @(negedge clk) begin
        logic sel, drv;
        #0.5;
        sel  = (mem_ce1_n === 1'b0) && (mem_ce2 === 1'b1);
        drv  = sel && (mem_oe_n === 1'b0) && (mem_we_n === 1'b1);
        s_wr = sel && (mem_we_n === 1'b0);
        s_a  = mem_addr;
        s_d  = mem_dq_o;
        if (drv && mem_dq_oe === 1'b1) contention++;
        mem_dq_i = drv ? peek(mem_addr) : 8'h00;
    end

    always @(posedge clk) begin
        if (s_wr) mem[int'(s_a)] = s_d;
        s_wr = 1'b0;
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_quiet(input string tag);
        check(mem_ce1_n === 1'b1 && mem_we_n === 1'b1 && mem_oe_n === 1'b1
              && mem_dq_oe === 1'b0, tag,
              {mem_ce1_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
    endtask

    task automatic test_reset();
        @(negedge clk); #0.5;
        check_quiet("R1 strobes during reset");
        check(rd_valid === 1'b0, "R1 rd_valid during reset", rd_valid, 0);
        @(posedge clk); #0.5 rst = 1'b0;
        @(negedge clk); #0.5;
        check_quiet("R1 strobes after reset");
        check(mem_ce2 === 1'b1, "R8 second select high", mem_ce2, 1);
    endtask

    task automatic write_word(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(posedge clk); #0.5;
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(posedge clk); #1;
        check_quiet("R3 high half during write");
        req_valid = 1'b0;
        @(negedge clk); #0.5;
        check(mem_ce1_n === 1'b0 && mem_we_n === 1'b0 && mem_oe_n === 1'b1
              && mem_dq_oe === 1'b1, "R4 write strobes",
              {mem_ce1_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b0011);
        check(mem_dq_o === d, "R4 write byte on bus", mem_dq_o, d);
        check(mem_addr === a, "R2 write address", mem_addr, a);
        @(posedge clk); #1;
        check(peek(a) === d, "R4 byte committed", peek(a), d);
    endtask

    task automatic read_word(input logic [AW-1:0] a, input logic [DW-1:0] exp);
        @(posedge clk); #0.5;
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(posedge clk); #1;
        check_quiet("R3 high half during read");
        req_valid = 1'b0;
        @(negedge clk); #0.5;
        check(mem_ce1_n === 1'b0 && mem_we_n === 1'b1 && mem_oe_n === 1'b0
              && mem_dq_oe === 1'b0, "R5 read strobes",
              {mem_ce1_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b0100);
        check(mem_addr === a, "R2 read address", mem_addr, a);
        @(posedge clk); #1;
        check(rd_valid === 1'b1, "R6 valid pulse", rd_valid, 1);
        check(rd_data === exp, "R6 read byte", rd_data, exp);
        @(posedge clk); #1;
        check(rd_valid === 1'b0, "R6 pulse one cycle", rd_valid, 0);
        check(rd_data === exp, "R6 byte held", rd_data, exp);
    endtask

    task automatic test_idle();
        @(posedge clk); #0.5 req_valid = 1'b0;
        @(negedge clk); #0.5;
        check_quiet("R7 idle cycle low half");
    endtask

    task automatic test_back_to_back();
        @(posedge clk); #0.5;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 13'h0AA; req_wdata = 8'h3C;
        @(posedge clk); #0.5;
        req_write = 1'b1; req_addr = 13'h0AB; req_wdata = 8'hC3;
        @(posedge clk); #0.5;
        req_write = 1'b0; req_addr = 13'h0AA;
        @(posedge clk); #0.5;
        req_write = 1'b0; req_addr = 13'h0AB;
        @(posedge clk); #0.5;
        req_valid = 1'b0;
        check(rd_valid === 1'b1 && rd_data === 8'h3C, "R10 first read back",
              rd_data, 8'h3C);
        @(posedge clk); #0.5;
        check(rd_valid === 1'b1 && rd_data === 8'hC3, "R10 second read back",
              rd_data, 8'hC3);
    endtask

    initial begin
        fork
            begin
                test_reset();
                write_word(13'h0000, 8'h5A);
                write_word(13'h1FFF, 8'hA5);
                test_idle();
                read_word(13'h0000, 8'h5A);
                read_word(13'h1FFF, 8'hA5);
                write_word(13'h0000, 8'hFF);
                read_word(13'h0000, 8'hFF);
                test_back_to_back();
                check(contention == 0, "R9 bus contention count", contention, 0);
                check(mem_ce2 === 1'b1, "R8 second select at end", mem_ce2, 1);
            end
            begin
                repeat (5000) @(posedge clk);
                check(1'b0, "watchdog expired", 0, 1);
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule